// File: doc/BRIEF.md
# Keyboard and Display Port Controller

This block sits on a simple CPU load/store bus and holds four word-addressed registers for one character input device and one character output device. A keyboard-side strobe delivers 8-bit character codes. Each code is held in an input data register, and a ready flag tells the CPU that a character is waiting. An output data register passes characters to a display through a valid/ack handshake. A second ready flag tells the CPU when the display can take the next character.

The ready flags lock each device out until software has acted. The keyboard side ignores new keystrokes until the waiting character has been read. The output side discards CPU writes until the display has acknowledged the previous character. Each status word also holds an interrupt-enable bit that the CPU can write. The block raises one interrupt request per device. It also contains the load-data multiplexer, which returns a device register when the address decodes to one of its four addresses and returns memory data otherwise.

Top module: `kbd_disp_port`

## Requirements
- R1: A read at 0xFE00 (input status), 0xFE02 (input data), 0xFE04 (output status) or 0xFE06 (output data) raises `io_sel` and returns that register on `rdata`. Any other address returns `mem_rdata`, with `io_sel` low.
- R2: When `key_strobe` is high at a clock edge and the input ready flag is clear, the code is captured. From the next cycle the input data register reads `{8'h00, code}` and input status bit 15 reads 1.
- R3: While input status bit 15 is set, strobes are ignored, and the input data register keeps the first character.
- R4: A read of 0xFE02 while the input ready flag is set clears input status bit 15 from the next cycle, and a later strobe is captured again.
- R5: A write to 0xFE06 while output status bit 15 is 1 drives `disp_char` with the write data bits [7:0], raises `disp_valid` and clears status bit 15 from the next cycle. Both outputs hold until `disp_ack` is seen. The cycle after an ack, `disp_valid` is low and status bit 15 is 1.
- R6: A write to 0xFE06 while output status bit 15 is 0 is discarded. `disp_char` does not change.
- R7: A write to either status register changes only bit 14, the interrupt enable. Bit 15 stays under hardware control, and bits 13:0 read as zero.
- R8: `kbd_irq` is high exactly when input status bits 15 and 14 are both 1. `disp_irq` follows the same rule for the output status register.
- R9: After reset, the input status reads 0x0000, the output status reads 0x8000, the input data register reads 0x0000, and `disp_valid` and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Load data from memory |
| rdata | output | 16 | Load data after the I/O multiplexer |
| io_sel | output | 1 | Address decodes to a device register |
| key_strobe | input | 1 | Keyboard has a new character |
| key_code | input | 8 | Character code from the keyboard |
| disp_valid | output | 1 | Character on disp_char awaits the display |
| disp_char | output | 8 | Character to the display |
| disp_ack | input | 1 | Display has consumed the character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| disp_irq | output | 1 | Display interrupt request |

## Verification
Characters are sent in several patterns: a single keystroke followed by a read, and a burst of keystrokes before any read. The burst separates capture from lockout, because only the first code may survive. A read followed by a fresh keystroke shows that capture is enabled again. On the output side, a write is followed by a second write before the ack, which tests the discard path. Status words are written with all ones and with all zeros, and the readback separates the writable enable bit from the hardware-owned ready bit. Reads at the even and odd addresses next to the I/O block test the multiplexer's choice between device registers and memory.

// File: rtl/kbd_disp_port.sv
module kbd_disp_port #(
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [15:0] KEY_STAT_ADDR = 16'hFE00,
  parameter logic [15:0] KEY_DATA_ADDR = 16'hFE02,
  parameter logic [15:0] SCR_STAT_ADDR = 16'hFE04,
  parameter logic [15:0] SCR_DATA_ADDR = 16'hFE06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rdata,
  output logic          io_sel,
  input  logic          key_strobe,
  input  logic [CW-1:0] key_code,
  output logic          disp_valid,
  output logic [CW-1:0] disp_char,
  input  logic          disp_ack,
  output logic          kbd_irq,
  output logic          disp_irq
);
  localparam int RDY = DW - 1;
  localparam int IEN = DW - 2;

  logic          key_rdy, key_ie, scr_rdy, scr_ie;
  logic [CW-1:0] key_q, scr_q;

  wire hit_ks = bus_addr == KEY_STAT_ADDR;
  wire hit_kd = bus_addr == KEY_DATA_ADDR;
  wire hit_ss = bus_addr == SCR_STAT_ADDR;
  wire hit_sd = bus_addr == SCR_DATA_ADDR;

  wire key_take = bus_rd & hit_kd;
  wire key_cap  = key_strobe & ~key_rdy;
  wire scr_put  = bus_wr & hit_sd & scr_rdy;
  wire scr_done = disp_ack & ~scr_rdy;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[RDY], bus_wdata[IEN-1:CW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_rdy <= 1'b0;
      key_ie  <= 1'b0;
      key_q   <= '0;
    end else begin
      if (key_cap) begin
        key_rdy <= 1'b1;
        key_q   <= key_code;
      end else if (key_take) begin
        key_rdy <= 1'b0;
      end
      if (bus_wr && hit_ks) key_ie <= bus_wdata[IEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_rdy <= 1'b1;
      scr_ie  <= 1'b0;
      scr_q   <= '0;
    end else begin
      if (scr_put) begin
        scr_rdy <= 1'b0;
        scr_q   <= bus_wdata[CW-1:0];
      end else if (scr_done) begin
        scr_rdy <= 1'b1;
      end
      if (bus_wr && hit_ss) scr_ie <= bus_wdata[IEN];
    end
  end

  assign io_sel     = hit_ks | hit_kd | hit_ss | hit_sd;
  assign disp_valid = ~scr_rdy;
  assign disp_char  = scr_q;
  assign kbd_irq    = key_rdy & key_ie;
  assign disp_irq   = scr_rdy & scr_ie;

  always_comb begin
    rdata = mem_rdata;
    if (hit_ks)      rdata = {key_rdy, key_ie, {(DW-2){1'b0}}};
    else if (hit_kd) rdata = {{(DW-CW){1'b0}}, key_q};
    else if (hit_ss) rdata = {scr_rdy, scr_ie, {(DW-2){1'b0}}};
    else if (hit_sd) rdata = {{(DW-CW){1'b0}}, scr_q};
  end

  AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    key_strobe && !key_rdy |=> key_rdy && key_q == $past(key_code)); // R2
  AST_KEY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    key_rdy && !key_take |=> key_rdy && $stable(key_q)); // R3
  AST_KEY_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    key_rdy && key_take |=> !key_rdy); // R4
  AST_SCR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ack |=> disp_valid && $stable(disp_char)); // R5
  AST_SCR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    !scr_rdy |=> $stable(disp_char)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_irq |-> key_ie) and (disp_irq |-> !disp_valid)); // R8
endmodule

// File: tb/kbd_disp_port_tb.sv
module kbd_disp_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] mem_rdata = 16'hA5A5;
  logic [15:0] rdata;
  logic        io_sel;
  logic        key_strobe = 1'b0;
  logic [7:0]  key_code = '0;
  logic        disp_valid;
  logic [7:0]  disp_char;
  logic        disp_ack = 1'b0;
  logic        kbd_irq, disp_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [16:0] q_val[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  kbd_disp_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .mem_rdata(mem_rdata),
    .rdata(rdata), .io_sel(io_sel), .key_strobe(key_strobe),
    .key_code(key_code), .disp_valid(disp_valid), .disp_char(disp_char),
    .disp_ack(disp_ack), .kbd_irq(kbd_irq), .disp_irq(disp_irq)
  );

  always @(negedge clk) begin
    if (bus_rd) begin
      n_cmp++;
      if (q_val.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        logic [16:0] e;
        string t;
        e = q_val.pop_front();
        t = q_tag.pop_front();
        if ({io_sel, rdata} !== e) begin
          n_bad++;
          $display("FAIL %s: actual io=%b data=%h expected io=%b data=%h",
                   t, io_sel, rdata, e[16], e[15:0]);
        end
      end
    end
  end

  task automatic bus_read(input logic [15:0] a, input logic [15:0] exp,
                          input logic io, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    q_val.push_back({io, exp});
    q_tag.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic press(input logic [7:0] c);
    @(posedge clk); #1;
    key_code = c; key_strobe = 1'b1;
    @(posedge clk); #1;
    key_strobe = 1'b0;
  endtask

  task automatic ack;
    @(posedge clk); #1;
    disp_ack = 1'b1;
    @(posedge clk); #1;
    disp_ack = 1'b0;
  endtask

  task automatic chk(input logic [15:0] got, input logic [15:0] exp,
                     input string tag);
    @(negedge clk);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9 reset state
    bus_read(16'hFE00, 16'h0000, 1'b1, "R9 key status");
    bus_read(16'hFE04, 16'h8000, 1'b1, "R9 scr status");
    bus_read(16'hFE02, 16'h0000, 1'b1, "R9 key data");
    chk({15'b0, disp_valid}, 16'd0, "R9 disp_valid");
    chk({14'b0, kbd_irq, disp_irq}, 16'd0, "R9 irqs");
    // R1 memory pass-through
    bus_read(16'h3000, 16'hA5A5, 1'b0, "R1 mem addr");
    bus_read(16'hFE01, 16'hA5A5, 1'b0, "R1 odd addr");
    bus_read(16'hFE08, 16'hA5A5, 1'b0, "R1 next addr");
    // R2 / R3 / R4 keyboard
    press(8'h41);
    bus_read(16'hFE00, 16'h8000, 1'b1, "R2 ready set");
    press(8'h42);
    press(8'h43);
    bus_read(16'hFE02, 16'h0041, 1'b1, "R3 lockout keeps first");
    bus_read(16'hFE00, 16'h0000, 1'b1, "R4 ready cleared");
    press(8'h44);
    bus_read(16'hFE02, 16'h0044, 1'b1, "R4 capture re-enabled");
    // R7 / R8 keyboard enable
    bus_write(16'hFE00, 16'hFFFF);
    bus_read(16'hFE00, 16'h4000, 1'b1, "R7 only enable written");
    chk({15'b0, kbd_irq}, 16'd0, "R8 kbd irq needs ready");
    press(8'h61);
    chk({15'b0, kbd_irq}, 16'd1, "R8 kbd irq raised");
    bus_read(16'hFE00, 16'hC000, 1'b1, "R8 key status both");
    bus_read(16'hFE02, 16'h0061, 1'b1, "R2 lowercase code");
    chk({15'b0, kbd_irq}, 16'd0, "R8 kbd irq dropped");
    // R5 / R6 display
    bus_write(16'hFE04, 16'h0000);
    bus_read(16'hFE04, 16'h8000, 1'b1, "R7 ready not writable");
    bus_write(16'hFE06, 16'h1234);
    chk({15'b0, disp_valid}, 16'd1, "R5 valid raised");
    chk({8'b0, disp_char}, 16'h0034, "R5 char driven");
    bus_read(16'hFE04, 16'h0000, 1'b1, "R5 scr busy");
    bus_write(16'hFE06, 16'h0055);
    chk({8'b0, disp_char}, 16'h0034, "R6 write discarded");
    chk({15'b0, disp_valid}, 16'd1, "R5 valid held");
    ack();
    chk({15'b0, disp_valid}, 16'd0, "R5 valid after ack");
    bus_read(16'hFE04, 16'h8000, 1'b1, "R5 ready after ack");
    bus_write(16'hFE04, 16'h4000);
    chk({15'b0, disp_irq}, 16'd1, "R8 disp irq raised");
    bus_read(16'hFE04, 16'hC000, 1'b1, "R8 scr status both");
    bus_write(16'hFE06, 16'h0077);
    chk({15'b0, disp_irq}, 16'd0, "R8 disp irq dropped");
    chk({8'b0, disp_char}, 16'h0077, "R5 second char");
    repeat (2) @(posedge clk);
    if (q_val.size() != 0) begin
      n_bad++;
      $display("FAIL R1 scoreboard: actual %0d left expected 0", q_val.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule